// File: doc/BRIEF.md
# Dual-Rail Ripple-Carry Adder with Completion Detection

This block adds two unsigned operands and a carry-in. Every bit travels on a pair of wires: one rail for 0 and one for 1. Operands arrive as valid codes and return to the all-empty spacer between operations, in a four-phase return-to-zero handshake. There is no fixed evaluation window. Instead, each position resolves its carry as early as its own operand bits allow. A completion flag tells the consumer when the whole result, sum and carry-out, holds valid codes, and again when it has emptied.

The implementation is clocked, so it fits a synchronous fabric. The operands are captured into a register. After that, the carry of each position is re-evaluated on every clock edge. A position whose two operand bits are equal settles on the first edge after capture, whatever carry it receives. A position whose operand bits differ waits one edge for the carry from its neighbour to arrive. The result latency therefore follows the longest run of propagating positions in the actual data, not the word width. An illegal 11 pair on any input raises a sticky error flag, and the affected position's outputs stay empty.

Top module: `dr_adder_top`

## Requirements
- R1: Each bit is a rail pair, with bit i on rails [2i+1:2i]. The codes are 00 empty, 01 valid zero, 10 valid one, and 11 illegal. No sum or carry-out pair is ever 11.
- R2: Once done is high, the decoded sum and carry-out equal the integer sum a + b + cin of the decoded inputs.
- R3: A position whose operand bits are equal and valid produces its carry on the first edge after capture: 01 for two zeros, 10 for two ones. The carry-in has no effect on this timing.
- R4: A position whose operand bits differ passes its incoming valid carry on, one edge later. Its sum becomes valid one edge after its incoming carry is valid.
- R5: Call the capture edge 0. The carry of position i is valid at edge t(i). Here t(0) = 1, and t(i) = 1 if bit i of a equals bit i of b, else t(i-1) + 1. Sum bit 0 is valid at edge 1, sum bit i at edge t(i-1) + 1, and the carry-out at edge t(W-1) + 1. done rises exactly one edge after the last of these. As examples, 0 + 0 completes at edge 3, and all-ones + 1 completes at edge W + 2.
- R6: done rises only when every sum pair and the carry-out are valid. Once high, done stays high until every one of them is 00 again.
- R7: After all inputs return to 00, the sum pairs are empty at edge 1, the carry-out is empty at edge 2, and done falls at edge 3.
- R8: While any operand pair of a position is 00, that position's sum stays 00 and done stays low.
- R9: A 11 pair on any operand or carry-in input sets err one edge after capture. err stays set until reset. While the pair is 11, that position's sum stays 00 and done stays low.
- R10: The synchronous active-high reset empties all sum and carry-out pairs and clears done and err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_rails | input | 2*WIDTH | Operand A, a rail pair per bit |
| b_rails | input | 2*WIDTH | Operand B, a rail pair per bit |
| cin_rails | input | 2 | Carry-in rail pair |
| sum_rails | output | 2*WIDTH | Sum, a rail pair per bit |
| cout_rails | output | 2 | Carry-out rail pair |
| done | output | 1 | Completion: all outputs valid (high) or all empty (low) |
| err | output | 1 | Sticky flag for an illegal 11 input pair |

## Verification
The bench uses several directed operand shapes. All-kill and all-generate words have no chain at all, so they show whether done arrives at the minimum latency regardless of carry-in. All-ones plus one, and all-ones plus zero with a carry-in, force one chain across the full width and separate true ripple from early resolution. Random pairs cover mixed chain lengths; half of them use a complemented operand to make long propagate runs. For each case the exact completion edge is compared with a bench model of the chain lengths, along with the decoded result and the release timing. A partly empty operand and an illegal pair show that incomplete or corrupt data never reports completion.

// File: rtl/dra_pkg.sv
package dra_pkg;
  typedef logic [1:0] rail_t;

  localparam rail_t RAIL_NULL = 2'b00;
  localparam rail_t RAIL_LO   = 2'b01;
  localparam rail_t RAIL_HI   = 2'b10;
  localparam rail_t RAIL_BAD  = 2'b11;

  typedef enum logic [1:0] {CK_NONE, CK_KILL, CK_GEN, CK_PROP} carry_kind_e;

  function automatic logic rail_ok(rail_t r);
    return (r == RAIL_LO) || (r == RAIL_HI);
  endfunction

  function automatic rail_t rail_of(logic v);
    return v ? RAIL_HI : RAIL_LO;
  endfunction

  // Classify a position from its two operand pairs.
  function automatic carry_kind_e classify(rail_t a, rail_t b);
    if (!rail_ok(a) || !rail_ok(b)) return CK_NONE;
    if (a != b) return CK_PROP;
    return a[1] ? CK_GEN : CK_KILL;
  endfunction
endpackage

// File: rtl/dra_capture.sv
module dra_capture import dra_pkg::*; #(
  parameter int WIDTH = 32,
  localparam int RW = 2 * WIDTH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] a_in,
  input  logic [RW-1:0] b_in,
  input  logic [1:0]    cin_in,
  output logic [RW-1:0] a_q,
  output logic [RW-1:0] b_q,
  output logic [1:0]    cin_q,
  output logic          err_q
);
  logic [WIDTH:0] bad_pos;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bad
    assign bad_pos[i] = (a_q[2*i +: 2] == RAIL_BAD) || (b_q[2*i +: 2] == RAIL_BAD);
  end
  assign bad_pos[WIDTH] = (cin_q == RAIL_BAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      cin_q <= RAIL_NULL;
      err_q <= 1'b0;
    end else begin
      a_q   <= a_in;
      b_q   <= b_in;
      cin_q <= cin_in;
      err_q <= err_q | (|bad_pos);
    end
  end

  // R9: an illegal captured pair flags err on the next edge
  assert_err_sets_R9: assert property (@(posedge clk) disable iff (rst)
    (|bad_pos) |=> err_q);
  // R9: err is sticky until reset
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: rtl/dra_carry_chain.sv
module dra_carry_chain import dra_pkg::*; #(
  parameter int WIDTH = 32,
  localparam int RW = 2 * WIDTH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] a_q,
  input  logic [RW-1:0] b_q,
  input  logic [1:0]    cin_q,
  output logic [RW-1:0] carry_q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    rail_t       c_in;
    rail_t       c_next;
    carry_kind_e kind;

    if (i == 0) begin : g_first
      assign c_in = cin_q;
    end else begin : g_rest
      assign c_in = carry_q[2*(i-1) +: 2];
    end

    assign kind = classify(a_q[2*i +: 2], b_q[2*i +: 2]);

    always_comb begin
      unique case (kind)
        CK_KILL: c_next = RAIL_LO;
        CK_GEN:  c_next = RAIL_HI;
        CK_PROP: c_next = rail_ok(c_in) ? c_in : RAIL_NULL;
        default: c_next = RAIL_NULL;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) carry_q[2*i +: 2] <= RAIL_NULL;
      else     carry_q[2*i +: 2] <= c_next;
    end

    // R3: two equal operand bits settle the carry on the next edge
    assert_kill_early_R3: assert property (@(posedge clk) disable iff (rst)
      (a_q[2*i +: 2] == RAIL_LO && b_q[2*i +: 2] == RAIL_LO) |=> carry_q[2*i +: 2] == RAIL_LO);
    assert_gen_early_R3: assert property (@(posedge clk) disable iff (rst)
      (a_q[2*i +: 2] == RAIL_HI && b_q[2*i +: 2] == RAIL_HI) |=> carry_q[2*i +: 2] == RAIL_HI);
    // R1: internal carry pairs are never illegal
    assert_carry_legal_R1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(carry_q[2*i +: 2]));
  end
endmodule

// File: rtl/dra_sum_stage.sv
module dra_sum_stage import dra_pkg::*; #(
  parameter int WIDTH = 32,
  localparam int RW = 2 * WIDTH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] a_q,
  input  logic [RW-1:0] b_q,
  input  logic [1:0]    cin_q,
  input  logic [RW-1:0] carry_q,
  output logic [RW-1:0] sum_q,
  output logic [1:0]    cout_q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    rail_t c_in;
    rail_t s_next;

    if (i == 0) begin : g_first
      assign c_in = cin_q;
    end else begin : g_rest
      assign c_in = carry_q[2*(i-1) +: 2];
    end

    always_comb begin
      if (rail_ok(a_q[2*i +: 2]) && rail_ok(b_q[2*i +: 2]) && rail_ok(c_in))
        s_next = rail_of(a_q[2*i+1] ^ b_q[2*i+1] ^ c_in[1]);
      else
        s_next = RAIL_NULL;
    end

    always_ff @(posedge clk) begin
      if (rst) sum_q[2*i +: 2] <= RAIL_NULL;
      else     sum_q[2*i +: 2] <= s_next;
    end

    // R1: sum pairs never carry the illegal code
    assert_sum_legal_R1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sum_q[2*i +: 2]));
    // R9: an illegal operand pair leaves its sum empty
    assert_bad_empty_R9: assert property (@(posedge clk) disable iff (rst)
      (a_q[2*i +: 2] == RAIL_BAD || b_q[2*i +: 2] == RAIL_BAD) |=> sum_q[2*i +: 2] == RAIL_NULL);
    // R8: an empty operand pair leaves its sum empty
    assert_empty_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (a_q[2*i +: 2] == RAIL_NULL || b_q[2*i +: 2] == RAIL_NULL) |=> sum_q[2*i +: 2] == RAIL_NULL);
  end

  always_ff @(posedge clk) begin
    if (rst) cout_q <= RAIL_NULL;
    else     cout_q <= carry_q[RW-2 +: 2];
  end

  assert_cout_legal_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cout_q));
endmodule

// File: rtl/dra_completion.sv
module dra_completion import dra_pkg::*; #(
  parameter int WIDTH = 32,
  localparam int RW = 2 * WIDTH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] sum_q,
  input  logic [1:0]    cout_q,
  output logic          done_q
);
  logic [WIDTH-1:0] pos_full;
  logic [WIDTH-1:0] pos_empty;
  logic             all_full;
  logic             all_empty;

  for (genvar i = 0; i < WIDTH; i++) begin : g_det
    assign pos_full[i]  = rail_ok(sum_q[2*i +: 2]);
    assign pos_empty[i] = (sum_q[2*i +: 2] == RAIL_NULL);
  end

  assign all_full  = (&pos_full) && rail_ok(cout_q);
  assign all_empty = (&pos_empty) && (cout_q == RAIL_NULL);

  always_ff @(posedge clk) begin
    if (rst)            done_q <= 1'b0;
    else if (all_full)  done_q <= 1'b1;
    else if (all_empty) done_q <= 1'b0;
  end

  // R6: done only rises on a fully valid result
  assert_done_rise_full_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> all_full);
  // R6: done only falls once every output has emptied
  assert_done_fall_empty_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(done_q) |-> all_empty);
endmodule

// File: rtl/dr_adder_top.sv
module dr_adder_top import dra_pkg::*; #(
  parameter int WIDTH = 32,
  localparam int RW = 2 * WIDTH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] a_rails,
  input  logic [RW-1:0] b_rails,
  input  logic [1:0]    cin_rails,
  output logic [RW-1:0] sum_rails,
  output logic [1:0]    cout_rails,
  output logic          done,
  output logic          err
);
  logic [RW-1:0] a_q;
  logic [RW-1:0] b_q;
  logic [1:0]    cin_q;
  logic [RW-1:0] carry_q;

  dra_capture #(.WIDTH(WIDTH)) u_capture (
    .clk(clk), .rst(rst),
    .a_in(a_rails), .b_in(b_rails), .cin_in(cin_rails),
    .a_q(a_q), .b_q(b_q), .cin_q(cin_q), .err_q(err)
  );

  dra_carry_chain #(.WIDTH(WIDTH)) u_chain (
    .clk(clk), .rst(rst),
    .a_q(a_q), .b_q(b_q), .cin_q(cin_q), .carry_q(carry_q)
  );

  dra_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .clk(clk), .rst(rst),
    .a_q(a_q), .b_q(b_q), .cin_q(cin_q), .carry_q(carry_q),
    .sum_q(sum_rails), .cout_q(cout_rails)
  );

  dra_completion #(.WIDTH(WIDTH)) u_done (
    .clk(clk), .rst(rst),
    .sum_q(sum_rails), .cout_q(cout_rails), .done_q(done)
  );

  // R10: reset leaves every output pair empty on the next cycle
  assert_reset_empty_R10: assert property (@(posedge clk)
    $past(rst) |-> (sum_rails == '0 && cout_rails == RAIL_NULL && !done && !err));
endmodule

// File: tb/dr_adder_top_tb_top.sv
module dr_adder_top_tb_top;
  localparam int W  = 32;
  localparam int RW = 2 * W;

  logic          clk = 1'b0;
  logic          rst;
  logic [RW-1:0] a_rails;
  logic [RW-1:0] b_rails;
  logic [1:0]    cin_rails;
  logic [RW-1:0] sum_rails;
  logic [1:0]    cout_rails;
  logic          done;
  logic          err;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  dr_adder_top #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .a_rails(a_rails), .b_rails(b_rails),
    .cin_rails(cin_rails), .sum_rails(sum_rails), .cout_rails(cout_rails),
    .done(done), .err(err)
  );

  function automatic logic [RW-1:0] enc(logic [W-1:0] v);
    logic [RW-1:0] r;
    for (int i = 0; i < W; i++) r[2*i +: 2] = v[i] ? 2'b10 : 2'b01;
    return r;
  endfunction

  function automatic logic all_valid(logic [RW-1:0] r);
    for (int i = 0; i < W; i++)
      if (r[2*i +: 2] != 2'b01 && r[2*i +: 2] != 2'b10) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [W-1:0] dec(logic [RW-1:0] r);
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = r[2*i+1];
    return v;
  endfunction

  // Completion edge predicted from the chain lengths of the data
  function automatic int expect_lat(logic [W-1:0] a, logic [W-1:0] b);
    int t_prev;
    int t_cur;
    int worst;
    t_prev = 1;
    worst  = 1;
    for (int i = 0; i < W; i++) begin
      if (i == 0) t_cur = 1;
      else begin
        t_cur = (a[i] == b[i]) ? 1 : t_prev + 1;
        if (t_prev + 1 > worst) worst = t_prev + 1;
      end
      t_prev = t_cur;
    end
    if (t_prev + 1 > worst) worst = t_prev + 1;
    return worst + 1;
  endfunction

  task automatic check(logic ok, string tag, longint actual, longint expected);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic drive(logic [RW-1:0] a, logic [RW-1:0] b, logic [1:0] c);
    @(negedge clk);
    a_rails   = a;
    b_rails   = b;
    cin_rails = c;
  endtask

  // Counts edges after the capture edge until done equals lvl
  task automatic wait_done(logic lvl, int limit, output int k);
    k = 0;
    forever begin
      @(posedge clk);
      @(negedge clk);
      if (done == lvl || k >= limit) break;
      k++;
    end
  endtask

  task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, logic c);
    int k;
    int lat;
    logic [W:0] want;
    logic [W:0] got;
    lat  = expect_lat(a, b);
    want = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    drive(enc(a), enc(b), c ? 2'b10 : 2'b01);
    wait_done(1'b1, 3 * W, k);
    check(k == lat, "R5 completion edge", k, lat);
    check(all_valid(sum_rails) && (cout_rails == 2'b01 || cout_rails == 2'b10),
          "R6 outputs valid at done", {cout_rails, sum_rails}, 0);
    got = {cout_rails[1], dec(sum_rails)};
    check(got == want, "R2 sum and carry-out", got, want);
    drive('0, '0, 2'b00);
    wait_done(1'b0, 3 * W, k);
    check(k == 3, "R7 release edge", k, 3);
    check(sum_rails == '0 && cout_rails == 2'b00, "R7 outputs empty",
          {cout_rails, sum_rails}, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    a_rails = '0;
    b_rails = '0;
    cin_rails = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [RW-1:0] ar;
    void'($urandom(32'd5151));
    do_reset();
    // R10: reset state
    check(sum_rails == '0 && cout_rails == 2'b00, "R10 outputs empty", {cout_rails, sum_rails}, 0);
    check(!done && !err, "R10 done and err low", {done, err}, 0);

    // R3: kill and generate everywhere complete at edge 3 for either carry-in
    run_op('0, '0, 1'b0);
    run_op('0, '0, 1'b1);
    run_op('1, '1, 1'b0);
    run_op('1, '1, 1'b1);
    // R4: full-width propagate chains
    run_op('1, 32'd1, 1'b0);
    run_op('1, '0, 1'b1);
    run_op(32'h5555_5555, 32'hAAAA_AAAA, 1'b1);
    run_op(32'h0000_FFFF, 32'h0000_0001, 1'b0);

    for (int n = 0; n < 150; n++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      a = $urandom();
      b = (n % 2 == 0) ? $urandom() : (~a ^ (32'h1 << ($urandom() % W)));
      run_op(a, b, 1'($urandom() % 2));
    end

    // R8: an empty operand pair holds its sum empty and done low
    ar = enc(32'h1234_5678);
    ar[2*5 +: 2] = 2'b00;
    drive(ar, enc(32'h0F0F_0F0F), 2'b01);
    repeat (3 * W) @(posedge clk);
    @(negedge clk);
    check(sum_rails[2*5 +: 2] == 2'b00, "R8 empty position sum", sum_rails[2*5 +: 2], 0);
    check(!done, "R8 done low on partial data", done, 0);
    drive('0, '0, 2'b00);
    repeat (4) @(posedge clk);

    // R9: illegal pair
    ar = enc(32'h0000_0008);
    ar[2*3 +: 2] = 2'b11;
    drive(ar, enc(32'h0000_0001), 2'b01);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(err, "R9 err set one edge after capture", err, 1);
    repeat (3 * W) @(posedge clk);
    @(negedge clk);
    check(sum_rails[2*3 +: 2] == 2'b00, "R9 illegal position sum empty", sum_rails[2*3 +: 2], 0);
    check(!done, "R9 done low with illegal pair", done, 0);
    drive('0, '0, 2'b00);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(err, "R9 err sticky", err, 1);
    do_reset();
    check(!err, "R10 reset clears err", err, 0);
    run_op(32'hFFFF_0000, 32'h0001_0000, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule